// File: doc/BRIEF.md
# Bus-Snooping Command and Operand Decoder

This block watches the bus of a 6502-family processor from the cartridge side and turns selected bus accesses into operand bytes and command codes for a coprocessor. Two zero-page locations act as data ports. A write to the operand location pushes the data byte onto a small operand stack. A write to the command location loads a command register and raises a command-valid flag. Two dedicated 256-byte pages act as address ports. Any access to one of these pages, read or write, delivers the low address byte in place of the data byte. So a single absolute NOP hands over a full byte and ties up no processor register.

Each bus cycle is taken exactly once, in the system clock cycle that sees the phase-2 clock fall. Software pushes the operands first and then issues the command that uses them. The coprocessor pops operands through a valid/ready port. It takes a command when `cmd_valid` is high and acknowledges it with `cmd_ack`.

Back-pressure rules:
- A pop happens on a clock edge where both `opnd_valid` and `opnd_ready` are high. `opnd_data` always shows the most recent byte still held.
- `cmd_valid` and `cmd_code` stay as they are until the edge where `cmd_ack` is high.

Top module: `bus_cmd_snoop`

## Requirements
- R1: A write (`bus_rnw`=0) to address 0x003E pushes the `bus_data` byte onto the operand stack.
- R2: A write to address 0x003F loads the `bus_data` byte into `cmd_code` and sets `cmd_valid`.
- R3: A read or a write anywhere in 0x1E00–0x1EFF pushes the low address byte, whatever `bus_data` holds.
- R4: A read or a write anywhere in 0x1F00–0x1FFF loads the low address byte into `cmd_code` and sets `cmd_valid`.
- R5: A bus access counts once, in the clock cycle where `bus_phi2` is first seen low after being high. Reads of 0x003E or 0x003F, and accesses to any other address, change nothing.
- R6: The stack is last-in first-out. `opnd_valid` is high while it holds a byte, and `opnd_data` is the newest byte. If a push and a pop share an edge, the pop takes the old top, the pushed byte becomes the new top, and the stack depth stays the same.
- R7: The stack holds 8 bytes. A push into a full stack, with no pop on the same edge, drops the byte and sets `stack_ovf`, which stays set until reset.
- R8: `cmd_valid` and `cmd_code` hold steady until an edge with `cmd_ack` high. With no new command on that edge, `cmd_valid` then falls.
- R9: A new command that arrives while `cmd_valid` is high and `cmd_ack` is low sets `cmd_ovr`, which stays set until reset, and the new code replaces the old one. A command that arrives on the same edge as `cmd_ack` leaves `cmd_ovr` clear and keeps `cmd_valid` high with the new code.
- R10: Reset (`rst_n` low) empties the stack and clears `cmd_valid`, `cmd_code`, `stack_ovf` and `cmd_ovr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; faster than the bus cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_phi2 | input | 1 | Phase-2 clock of the processor bus |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 13 | Bus address |
| bus_data | input | 8 | Bus data byte |
| opnd_valid | output | 1 | Operand stack holds at least one byte |
| opnd_ready | input | 1 | Consumer pops the top byte |
| opnd_data | output | 8 | Top byte of the operand stack |
| cmd_valid | output | 1 | A command is waiting |
| cmd_ack | input | 1 | Consumer takes the command |
| cmd_code | output | 8 | Current command code |
| stack_ovf | output | 1 | Sticky: a push was dropped on a full stack |
| cmd_ovr | output | 1 | Sticky: a command arrived before the previous one was taken |

## Verification
Two pairs of functions can land on the same clock edge. A snooped push can meet a consumer pop, and a snooped command can meet a consumer acknowledge. The bench provokes the first by holding `opnd_ready` high on the edge after `bus_phi2` falls while the stack is full. It expects the old top on `opnd_data` before that edge, the pushed byte afterwards, and `stack_ovf` still clear. It provokes the second by raising `cmd_ack` on the edge that takes a command-page access. It expects `cmd_valid` to stay high with the new code and `cmd_ovr` to stay clear. Both results are compared with the cases where the two functions fall on different edges.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef struct packed {
    logic       push;  // operand byte to be stacked
    logic       cmd;   // command byte to be latched
    logic [7:0] val;   // byte carried by the access
  } bus_evt_t;
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler
  import snoop_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter logic [7:0] OPND_ZP = 8'h3E,
  parameter logic [7:0] CMD_ZP = 8'h3F,
  parameter logic [ADDR_W-9:0] OPND_PAGE = 'h1E,
  parameter logic [ADDR_W-9:0] CMD_PAGE = 'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output bus_evt_t          evt
);
  localparam logic [ADDR_W-1:0] OPND_ZP_A = ADDR_W'(OPND_ZP);
  localparam logic [ADDR_W-1:0] CMD_ZP_A = ADDR_W'(CMD_ZP);

  logic phi2_q;
  logic fall;

  always_ff @(posedge clk) begin
    if (!rst_n) phi2_q <= 1'b0;
    else        phi2_q <= phi2;
  end

  assign fall = phi2_q & ~phi2;

  always_comb begin
    logic [ADDR_W-9:0] page;
    logic zp_opnd, zp_cmd, pg_opnd, pg_cmd;
    page    = addr[ADDR_W-1:8];
    zp_opnd = !rnw && (addr == OPND_ZP_A);
    zp_cmd  = !rnw && (addr == CMD_ZP_A);
    pg_opnd = (page == OPND_PAGE);
    pg_cmd  = (page == CMD_PAGE);
    evt.push = fall && (zp_opnd || pg_opnd);
    evt.cmd  = fall && (zp_cmd || pg_cmd);
    evt.val  = (pg_opnd || pg_cmd) ? addr[7:0] : data;
  end
endmodule

// File: rtl/operand_stack.sv
module operand_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_val,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         ovf
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] count;
  logic [CW-1:0] top_c;
  logic [AW-1:0] top_i, next_i;
  logic          pop;

  assign top_c     = count - 1'b1;
  assign top_i     = top_c[AW-1:0];
  assign next_i    = count[AW-1:0];
  assign out_valid = (count != '0);
  assign out_data  = out_valid ? mem[top_i] : '0;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (push && pop) begin
      mem[top_i] <= push_val;
    end else if (push) begin
      if (count == FULL) begin
        ovf <= 1'b1;
      end else begin
        mem[next_i] <= push_val;
        count       <= count + 1'b1;
      end
    end else if (pop) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/cmd_latch.sv
module cmd_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         ack,
  output logic         valid,
  output logic [W-1:0] code,
  output logic         ovr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      code  <= '0;
      ovr   <= 1'b0;
    end else if (load) begin
      code  <= load_val;
      valid <= 1'b1;
      if (valid && !ack) ovr <= 1'b1;
    end else if (ack) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_cmd_snoop.sv
module bus_cmd_snoop
  import snoop_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned STACK_DEPTH = 8,
  parameter logic [7:0] OPND_ZP = 8'h3E,
  parameter logic [7:0] CMD_ZP = 8'h3F,
  parameter logic [ADDR_W-9:0] OPND_PAGE = 'h1E,
  parameter logic [ADDR_W-9:0] CMD_PAGE = 'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_phi2,
  input  logic              bus_rnw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_data,
  output logic              opnd_valid,
  input  logic              opnd_ready,
  output logic [7:0]        opnd_data,
  output logic              cmd_valid,
  input  logic              cmd_ack,
  output logic [7:0]        cmd_code,
  output logic              stack_ovf,
  output logic              cmd_ovr
);
  bus_evt_t evt;
  logic     ev_push;
  logic     ev_cmd;

  bus_sampler #(
    .ADDR_W(ADDR_W), .OPND_ZP(OPND_ZP), .CMD_ZP(CMD_ZP),
    .OPND_PAGE(OPND_PAGE), .CMD_PAGE(CMD_PAGE)
  ) u_samp (
    .clk(clk), .rst_n(rst_n), .phi2(bus_phi2), .rnw(bus_rnw),
    .addr(bus_addr), .data(bus_data), .evt(evt)
  );

  assign ev_push = evt.push;
  assign ev_cmd  = evt.cmd;

  operand_stack #(.DEPTH(STACK_DEPTH), .W(8)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(ev_push), .push_val(evt.val),
    .out_valid(opnd_valid), .out_ready(opnd_ready), .out_data(opnd_data),
    .ovf(stack_ovf)
  );

  cmd_latch #(.W(8)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load(ev_cmd), .load_val(evt.val),
    .ack(cmd_ack), .valid(cmd_valid), .code(cmd_code), .ovr(cmd_ovr)
  );
endmodule

// File: rtl/snoop_chk.sv
module snoop_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_push,
  input logic       ev_cmd,
  input logic       opnd_valid,
  input logic       opnd_ready,
  input logic [7:0] opnd_data,
  input logic       cmd_valid,
  input logic       cmd_ack,
  input logic [7:0] cmd_code,
  input logic       stack_ovf,
  input logic       cmd_ovr
);
  // R5: one bus cycle yields at most one event, never two in a row
  a_r5_single_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push || ev_cmd) |=> !(ev_push || ev_cmd));

  // R6: an untouched top byte holds still
  a_r6_top_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_valid && !opnd_ready && !ev_push) |=> (opnd_valid && $stable(opnd_data)));

  // R7: overflow flag is sticky
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ovf |=> stack_ovf);

  // R8: a waiting command holds until acknowledged
  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ack && !ev_cmd) |=> (cmd_valid && $stable(cmd_code)));

  // R9: collision without acknowledge raises overrun
  a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ack && ev_cmd) |=> cmd_ovr);

  // R9: overrun flag is sticky
  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ovr |=> cmd_ovr);

  // R10: reset clears all outputs
  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!opnd_valid && !cmd_valid && !stack_ovf && !cmd_ovr && cmd_code == 8'h00));
endmodule

bind bus_cmd_snoop snoop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_push(ev_push), .ev_cmd(ev_cmd),
  .opnd_valid(opnd_valid), .opnd_ready(opnd_ready), .opnd_data(opnd_data),
  .cmd_valid(cmd_valid), .cmd_ack(cmd_ack), .cmd_code(cmd_code),
  .stack_ovf(stack_ovf), .cmd_ovr(cmd_ovr)
);

// File: tb/sim_bus_cmd_snoop.sv
module sim_bus_cmd_snoop;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_phi2 = 1'b0;
  logic        bus_rnw = 1'b1;
  logic [12:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        opnd_ready = 1'b0;
  logic        cmd_ack = 1'b0;
  logic        opnd_valid, cmd_valid, stack_ovf, cmd_ovr;
  logic [7:0]  opnd_data, cmd_code;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  bus_cmd_snoop u0 (
    .clk(clk), .rst_n(rst_n), .bus_phi2(bus_phi2), .bus_rnw(bus_rnw),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .opnd_valid(opnd_valid), .opnd_ready(opnd_ready), .opnd_data(opnd_data),
    .cmd_valid(cmd_valid), .cmd_ack(cmd_ack), .cmd_code(cmd_code),
    .stack_ovf(stack_ovf), .cmd_ovr(cmd_ovr)
  );

  // {addr, data, rnw, exp opnd_valid, exp top, exp cmd_valid, exp cmd_code}
  // R1 zero-page push, R3 page push with data ignored, R5 ignored accesses,
  // R2 zero-page command
  localparam logic [39:0] VEC [6] = '{
    {13'h003E, 8'h11, 1'b0, 1'b1, 8'h11, 1'b0, 8'h00},
    {13'h1E5A, 8'hAA, 1'b1, 1'b1, 8'h5A, 1'b0, 8'h00},
    {13'h003E, 8'h77, 1'b1, 1'b1, 8'h5A, 1'b0, 8'h00},
    {13'h0040, 8'h99, 1'b0, 1'b1, 8'h5A, 1'b0, 8'h00},
    {13'h1E33, 8'hFF, 1'b0, 1'b1, 8'h33, 1'b0, 8'h00},
    {13'h003F, 8'h05, 1'b0, 1'b1, 8'h33, 1'b1, 8'h05}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One bus cycle; ack_now / pop_now are held on the sampling edge only
  task automatic bus_cycle(input logic [12:0] a, input logic [7:0] d, input logic rnw,
                           input logic ack_now, input logic pop_now);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_rnw = rnw; bus_phi2 = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_phi2 = 1'b0; cmd_ack = ack_now; opnd_ready = pop_now;
    @(negedge clk);
    cmd_ack = 1'b0; opnd_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop_one(input string tag, input logic [7:0] exp);
    @(negedge clk);
    chk(tag, {31'd0, opnd_valid}, 32'd1);
    chk(tag, {24'd0, opnd_data}, {24'd0, exp});
    opnd_ready = 1'b1;
    @(negedge clk);
    opnd_ready = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 opnd_valid", {31'd0, opnd_valid}, 32'd0);
    chk("R10 cmd_valid", {31'd0, cmd_valid}, 32'd0);
    chk("R10 flags", {30'd0, stack_ovf, cmd_ovr}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) begin
      bus_cycle(VEC[i][39:27], VEC[i][26:19], VEC[i][18], 1'b0, 1'b0);
      chk($sformatf("R1/R2/R3/R5 vec%0d opnd", i), {23'd0, opnd_valid, opnd_data},
          {23'd0, VEC[i][17], VEC[i][16:9]});
      chk($sformatf("R2 vec%0d cmd", i), {23'd0, cmd_valid, cmd_code},
          {23'd0, VEC[i][8], VEC[i][7:0]});
    end

    // R8: command holds while unacknowledged
    repeat (6) @(negedge clk);
    chk("R8 cmd held", {23'd0, cmd_valid, cmd_code}, {23'd0, 1'b1, 8'h05});
    cmd_ack = 1'b1;
    @(negedge clk);
    cmd_ack = 1'b0;
    chk("R8 ack clears", {31'd0, cmd_valid}, 32'd0);

    // R6: LIFO order; R5: each access counted once
    pop_one("R6 pop1", 8'h33);
    pop_one("R6 pop2", 8'h5A);
    pop_one("R5 pop3", 8'h11);
    chk("R6 empty", {31'd0, opnd_valid}, 32'd0);

    // R4: command page, read access
    bus_cycle(13'h1F21, 8'hEE, 1'b1, 1'b0, 1'b0);
    chk("R4 page cmd", {23'd0, cmd_valid, cmd_code}, {23'd0, 1'b1, 8'h21});
    chk("R9 no ovr yet", {31'd0, cmd_ovr}, 32'd0);
    // R9: collision without ack
    bus_cycle(13'h003F, 8'h44, 1'b0, 1'b0, 1'b0);
    chk("R9 ovr set", {31'd0, cmd_ovr}, 32'd1);
    chk("R9 code replaced", {24'd0, cmd_code}, 32'h44);

    // R10: reset clears flags and command
    do_reset();
    @(negedge clk);
    chk("R10 cleared", {29'd0, cmd_valid, cmd_ovr, stack_ovf}, 32'd0);
    chk("R10 code", {24'd0, cmd_code}, 32'd0);

    // R9: command arriving on the ack edge
    bus_cycle(13'h1F10, 8'h00, 1'b0, 1'b0, 1'b0);
    bus_cycle(13'h1F20, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R9 ack same edge", {22'd0, cmd_ovr, cmd_valid, cmd_code}, {22'd0, 1'b0, 1'b1, 8'h20});

    // R7: fill the stack
    for (int k = 0; k < 8; k++) bus_cycle(13'h1E00 + 13'(k), 8'hC3, 1'b1, 1'b0, 1'b0);
    chk("R7 full no ovf", {23'd0, stack_ovf, opnd_data}, {23'd0, 1'b0, 8'h07});
    // R6: push and pop on the same edge while full
    bus_cycle(13'h1E08, 8'h00, 1'b1, 1'b0, 1'b1);
    chk("R6 swap top", {23'd0, stack_ovf, opnd_data}, {23'd0, 1'b0, 8'h08});
    // R7: push into full stack is dropped
    bus_cycle(13'h1E09, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R7 ovf set", {23'd0, stack_ovf, opnd_data}, {23'd0, 1'b1, 8'h08});
    pop_one("R7 pop top", 8'h08);
    for (int k = 6; k >= 0; k--) pop_one("R7 drain", 8'(k));
    chk("R7 depth 8", {31'd0, opnd_valid}, 32'd0);
    chk("R7 ovf sticky", {31'd0, stack_ovf}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule